// File: doc/BRIEF.md
# UART Interrupt Identification and Arbitration

This block decides which of the five interrupt sources of a 16550-style serial port is reported to the host, and drives the single interrupt line. It holds the interrupt-enable byte, the sticky error bits and transmitter flags of the line status byte, and the pending flag for the transmit-holding-empty source. It also applies the side effects that host register accesses have on that state.

The receive FIFO, the shifters and the baud generator sit outside. They appear here as plain inputs: a data-ready level, a FIFO fill count with its trigger level, a character-timeout flag, parity and framing error levels, overrun and break event pulses, a "holding register drained" pulse, a "transmitter idle" pulse and the four modem-status delta bits. The host side is a one-cycle access strobe with a 3-bit register address. Read data is registered and appears on `rd_data` one cycle after the strobe. It keeps that value until the next read.

Top module: `uart_irq_arb`

## Requirements
- R1: When several sources are active, the identification code follows this fixed precedence: line status first, then character timeout, then received data, then transmit holding empty, then modem status.
- R2: A read of address 2 returns the identification byte. Bits 3:0 hold the code: 0x6 line status, 0xC timeout, 0x4 received data, 0x2 holding empty, 0x0 modem status, 0x1 nothing pending. Bits 5:4 read 0. Bits 7:6 read 11 when `fifo_en` is high and 00 otherwise.
- R3: A line status interrupt needs enable bit 2 and at least one of status bits 1 (overrun), 2 (parity), 3 (framing) or 4 (break).
- R4: The character-timeout interrupt is raised only when `rx_timeout` is high and enable bit 0 is set.
- R5: A received-data interrupt needs enable bit 0 and `rx_ready`. With `fifo_en` high it also needs `rx_count >= rx_trig`.
- R6: A `thr_drained` pulse sets status bit 5 and the holding-empty pending flag. A `tx_idle` pulse sets status bit 6. A write to address 0 clears the pending flag and status bits 5 and 6. A read of address 2 whose code is 0x2 clears the pending flag.
- R7: A write to address 1 stores the low 4 bits of the data as the enable byte, and a read of address 1 returns them with upper bits 0. If the write changes enable bit 1, the pending flag becomes (new bit 1 AND status bit 5). A write that leaves bit 1 unchanged does not touch the flag.
- R8: A read of address 5 returns the status byte {0, bit6, bit5, break, framing, parity, overrun, `rx_ready`}, then clears the break and overrun bits.
- R9: `irq` is a register that is high exactly when the code computed in the previous cycle was not 0x1.
- R10: After reset the enable byte is 0, the identification byte reads 0x01, the status byte reads 0x60, the pending flag is clear and `irq` is low.
- R11: A modem status interrupt needs enable bit 3 and at least one set bit of `msr_delta`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Host access strobe, one cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| fifo_en | input | 1 | FIFO mode active |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | CW | Receive trigger level |
| rx_ready | input | 1 | Received data available |
| rx_timeout | input | 1 | Character timeout pending |
| parity_err | input | 1 | Parity error level |
| frame_err | input | 1 | Framing error level |
| overrun_ev | input | 1 | Overrun event pulse |
| break_ev | input | 1 | Break event pulse |
| thr_drained | input | 1 | Holding register emptied pulse |
| tx_idle | input | 1 | Transmitter fully idle pulse |
| msr_delta | input | 4 | Modem-status change bits |
| irq | output | 1 | Interrupt request level |

## Verification
Every source is first raised alone, both with and without its enable bit, so that the code and the gating are confirmed one source at a time. All five sources are then stacked and removed from the top down, which exposes any swap in the precedence. Data-ready is tried with the FIFO off, and with the FIFO on at counts below, at and above the trigger level, which separates the two data-ready rules. The holding-empty flag is driven through every path that sets or clears it: drain, identification read, THR write, enable toggle and an enable rewrite with bit 1 unchanged. This tells a true re-arm apart from a stale flag.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam logic [3:0] ID_NONE = 4'h1;
  localparam logic [3:0] ID_LINE = 4'h6;
  localparam logic [3:0] ID_TMO  = 4'hC;
  localparam logic [3:0] ID_RXD  = 4'h4;
  localparam logic [3:0] ID_THR  = 4'h2;
  localparam logic [3:0] ID_MDM  = 4'h0;

  localparam logic [2:0] A_THR = 3'd0;
  localparam logic [2:0] A_IER = 3'd1;
  localparam logic [2:0] A_IIR = 3'd2;
  localparam logic [2:0] A_LSR = 3'd5;

  typedef struct packed {
    logic temt;
    logic thre;
    logic bi;
    logic fe;
    logic pe;
    logic oe;
    logic dr;
  } line_stat_t;
endpackage

// File: rtl/uart_irq_state.sv
module uart_irq_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       ier_wr,
  input  logic [3:0] ier_wdata,
  input  logic       thr_wr,
  input  logic       iir_rd,
  input  logic       iir_is_thr,
  input  logic       lsr_rd,
  input  logic       drain_ev,
  input  logic       idle_ev,
  input  logic       ovr_ev,
  input  logic       brk_ev,
  output logic [3:0] ier_q,
  output logic       thre_q,
  output logic       temt_q,
  output logic       oe_q,
  output logic       bi_q,
  output logic       pend_q
);
  logic thri_flip;
  assign thri_flip = ier_wr && (ier_wdata[1] != ier_q[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q  <= 4'h0;
      thre_q <= 1'b1;
      temt_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata;
      if (drain_ev) begin
        thre_q <= 1'b1;
        pend_q <= 1'b1;
      end
      if (idle_ev) temt_q <= 1'b1;
      if (iir_rd && iir_is_thr) pend_q <= 1'b0;
      if (thri_flip) pend_q <= ier_wdata[1] & thre_q;
      if (thr_wr) begin
        thre_q <= 1'b0;
        temt_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q <= 1'b0;
      bi_q <= 1'b0;
    end else begin
      if (lsr_rd) begin
        oe_q <= 1'b0;
        bi_q <= 1'b0;
      end
      if (ovr_ev) oe_q <= 1'b1;
      if (brk_ev) bi_q <= 1'b1;
    end
  end

  AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (!thre_q && !temt_q && !pend_q)); // R6
  AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !ovr_ev && !brk_ev) |=> (!oe_q && !bi_q)); // R8
  AST_IER_STORES_LOW: assert property (@(posedge clk) disable iff (rst)
    ier_wr |=> (ier_q == $past(ier_wdata))); // R7
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    ier,
  input  logic [3:0]    err_bits,
  input  logic          dr,
  input  logic          fifo_en,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  input  logic          tmo,
  input  logic          thr_pend,
  input  logic [3:0]    mdm_delta,
  output logic [3:0]    code
);
  import uart_irq_pkg::*;

  logic line_hit, tmo_hit, rxd_hit, thr_hit, mdm_hit, level_ok;

  assign level_ok = !fifo_en || (count >= trig);
  assign line_hit = ier[2] && (|err_bits);
  assign tmo_hit  = ier[0] && tmo;
  assign rxd_hit  = ier[0] && dr && level_ok;
  assign thr_hit  = ier[1] && thr_pend;
  assign mdm_hit  = ier[3] && (|mdm_delta);

  always_comb begin
    if (line_hit)     code = ID_LINE;
    else if (tmo_hit) code = ID_TMO;
    else if (rxd_hit) code = ID_RXD;
    else if (thr_hit) code = ID_THR;
    else if (mdm_hit) code = ID_MDM;
    else              code = ID_NONE;
  end

  AST_TMO_NEEDS_RXEN: assert property (@(posedge clk) disable iff (rst)
    (code == ID_TMO) |-> (ier[0] && tmo)); // R4
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ier[2] && (|err_bits)) |-> (code == ID_LINE)); // R1
endmodule

// File: rtl/uart_irq_rdport.sv
module uart_irq_rdport (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [3:0] ier,
  input  logic [7:0] iir,
  input  logic [7:0] lsr,
  output logic [7:0] rd_data
);
  import uart_irq_pkg::*;

  logic [7:0] sel;
  always_comb begin
    case (addr)
      A_IER:   sel = {4'h0, ier};
      A_IIR:   sel = iir;
      A_LSR:   sel = lsr;
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb #(
  parameter int FIFO_DEPTH = 16,
  parameter int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [2:0]    acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic [7:0]    rd_data,
  input  logic          fifo_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_ready,
  input  logic          rx_timeout,
  input  logic          parity_err,
  input  logic          frame_err,
  input  logic          overrun_ev,
  input  logic          break_ev,
  input  logic          thr_drained,
  input  logic          tx_idle,
  input  logic [3:0]    msr_delta,
  output logic          irq
);
  import uart_irq_pkg::*;

  logic       wr_any, rd_any;
  logic       ier_wr, thr_wr, iir_rd, lsr_rd;
  logic [3:0] ier_q;
  logic       thre_q, temt_q, oe_q, bi_q, pend_q;
  logic [3:0] code;
  logic [7:0] iir_byte, lsr_byte;
  line_stat_t lstat;

  assign wr_any = acc_en && acc_we;
  assign rd_any = acc_en && !acc_we;
  assign ier_wr = wr_any && (acc_addr == A_IER);
  assign thr_wr = wr_any && (acc_addr == A_THR);
  assign iir_rd = rd_any && (acc_addr == A_IIR);
  assign lsr_rd = rd_any && (acc_addr == A_LSR);

  uart_irq_state u_state (
    .clk(clk), .rst(rst),
    .ier_wr(ier_wr), .ier_wdata(acc_wdata[3:0]),
    .thr_wr(thr_wr), .iir_rd(iir_rd), .iir_is_thr(code == ID_THR),
    .lsr_rd(lsr_rd), .drain_ev(thr_drained), .idle_ev(tx_idle),
    .ovr_ev(overrun_ev), .brk_ev(break_ev),
    .ier_q(ier_q), .thre_q(thre_q), .temt_q(temt_q),
    .oe_q(oe_q), .bi_q(bi_q), .pend_q(pend_q)
  );

  assign lstat = '{temt: temt_q, thre: thre_q, bi: bi_q, fe: frame_err,
                   pe: parity_err, oe: oe_q, dr: rx_ready};
  assign lsr_byte = {1'b0, lstat};

  uart_irq_prio #(.CW(CW)) u_prio (
    .clk(clk), .rst(rst),
    .ier(ier_q), .err_bits({lstat.bi, lstat.fe, lstat.pe, lstat.oe}),
    .dr(rx_ready), .fifo_en(fifo_en), .count(rx_count), .trig(rx_trig),
    .tmo(rx_timeout), .thr_pend(pend_q), .mdm_delta(msr_delta),
    .code(code)
  );

  assign iir_byte = {{2{fifo_en}}, 2'b00, code};

  uart_irq_rdport u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_any), .addr(acc_addr),
    .ier(ier_q), .iir(iir_byte), .lsr(lsr_byte), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (code != ID_NONE);
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == !$past(code[0]))); // R9
endmodule

// File: tb/uart_irq_arb_bench.sv
module uart_irq_arb_bench;
  localparam int PERIOD = 10;
  localparam int CW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic acc_en = 0, acc_we = 0;
  logic [2:0] acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] rd_data;
  logic fifo_en = 0, rx_ready = 0, rx_timeout = 0, parity_err = 0, frame_err = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 1;
  logic overrun_ev = 0, break_ev = 0, thr_drained = 0, tx_idle = 0;
  logic [3:0] msr_delta = 0;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  uart_irq_arb u_uart_irq_arb (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_ev(overrun_ev), .break_ev(break_ev), .thr_drained(thr_drained),
    .tx_idle(tx_idle), .msr_delta(msr_delta), .irq(irq)
  );

  // behavioural reference model
  int m_ier; bit m_thre, m_temt, m_oe, m_bi, m_pend;
  int exp_rd; bit exp_irq;

  function automatic int m_code();
    if ((m_ier & 4) && (m_oe || parity_err || frame_err || m_bi)) return 6;
    if ((m_ier & 1) && rx_timeout) return 12;
    if ((m_ier & 1) && rx_ready && (!fifo_en || rx_count >= rx_trig)) return 4;
    if ((m_ier & 2) && m_pend) return 2;
    if ((m_ier & 8) && msr_delta != 0) return 0;
    return 1;
  endfunction

  function automatic int m_lsr();
    return (m_temt << 6) | (m_thre << 5) | (m_bi << 4) | (frame_err << 3) |
           (parity_err << 2) | (m_oe << 1) | rx_ready;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ier = 0; m_thre = 1; m_temt = 1; m_oe = 0; m_bi = 0; m_pend = 0;
      exp_rd = 0; exp_irq = 0;
    end else begin
      int c;
      c = m_code();
      exp_irq = (c != 1);
      if (acc_en && !acc_we) begin
        case (acc_addr)
          3'd1: exp_rd = m_ier;
          3'd2: exp_rd = (fifo_en ? 8'hC0 : 8'h00) | c;
          3'd5: exp_rd = m_lsr();
          default: exp_rd = 0;
        endcase
      end
      if (thr_drained) begin m_thre = 1; m_pend = 1; end
      if (tx_idle) m_temt = 1;
      if (acc_en && !acc_we && acc_addr == 3'd2 && c == 2) m_pend = 0;
      if (acc_en && !acc_we && acc_addr == 3'd5) begin m_oe = 0; m_bi = 0; end
      if (overrun_ev) m_oe = 1;
      if (break_ev) m_bi = 1;
      if (acc_en && acc_we && acc_addr == 3'd1) begin
        if (((acc_wdata >> 1) & 1) != ((m_ier >> 1) & 1))
          m_pend = acc_wdata[1] && m_thre;
        m_ier = acc_wdata & 8'h0F;
      end
      if (acc_en && acc_we && acc_addr == 3'd0) begin
        m_thre = 0; m_temt = 0; m_pend = 0;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(irq == exp_irq, "R9 irq per-cycle", irq, exp_irq);
    check(rd_data == exp_rd[7:0], "R2 rd_data per-cycle", rd_data, exp_rd);
    acc_en = 0; acc_we = 0; thr_drained = 0; tx_idle = 0;
    overrun_ev = 0; break_ev = 0;
  endtask

  task automatic rd(input logic [2:0] a, input int expv, input string tag);
    acc_en = 1; acc_we = 0; acc_addr = a;
    step();
    check(rd_data == expv[7:0], tag, rd_data, expv);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    step();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    // R10 reset state
    check(irq == 0, "R10 irq after reset", irq, 0);
    rd(3'd2, 8'h01, "R10 IIR reset");
    rd(3'd5, 8'h60, "R10 LSR reset");
    rd(3'd1, 8'h00, "R10 IER reset");
    // R7 enable write, upper bits dropped, THRI re-arm; R9 lag
    wr(3'd1, 8'hF2);
    check(irq == 0, "R9 irq one cycle late", irq, 0);
    step();
    check(irq == 1, "R9 irq raised", irq, 1);
    rd(3'd1, 8'h02, "R7 IER low nibble");
    // R6 IIR read clears pending
    rd(3'd2, 8'h02, "R6 IIR shows THR empty");
    rd(3'd2, 8'h01, "R6 IIR read cleared pending");
    wr(3'd1, 8'h02);
    rd(3'd2, 8'h01, "R7 unchanged THRI keeps flag");
    wr(3'd1, 8'h00); wr(3'd1, 8'h02);
    rd(3'd2, 8'h02, "R7 THRI toggle re-arms");
    // R6 THR write and drain
    wr(3'd0, 8'h55);
    rd(3'd5, 8'h00, "R6 THR write clears THRE/TEMT");
    rd(3'd2, 8'h01, "R6 THR write clears pending");
    wr(3'd1, 8'h00); wr(3'd1, 8'h02);
    rd(3'd2, 8'h01, "R7 no re-arm while THRE low");
    thr_drained = 1; step();
    rd(3'd5, 8'h20, "R6 drain sets THRE");
    tx_idle = 1; step();
    rd(3'd5, 8'h60, "R6 idle sets TEMT");
    rd(3'd2, 8'h02, "R6 drain sets pending");
    // R11 modem
    wr(3'd1, 8'h08);
    msr_delta = 4'h4; step();
    rd(3'd2, 8'h00, "R11 modem code");
    wr(3'd1, 8'h00);
    rd(3'd2, 8'h01, "R11 modem masked");
    msr_delta = 0;
    // R5 received data
    wr(3'd1, 8'h01);
    rx_ready = 1; step();
    rd(3'd2, 8'h04, "R5 data ready, FIFO off");
    fifo_en = 1; rx_trig = 4; rx_count = 3; step();
    rd(3'd2, 8'hC1, "R5 below trigger (R2 FIFO bits)");
    rx_count = 4; step();
    rd(3'd2, 8'hC4, "R5 at trigger");
    rx_count = 5; step();
    rd(3'd2, 8'hC4, "R5 above trigger");
    // R4 timeout
    rx_timeout = 1; step();
    rd(3'd2, 8'hCC, "R4 timeout beats data (R1)");
    wr(3'd1, 8'h00);
    rd(3'd2, 8'hC1, "R4 timeout masked by bit 0");
    rx_timeout = 0;
    // R3 line status
    parity_err = 1; step();
    rd(3'd2, 8'hC1, "R3 parity masked");
    wr(3'd1, 8'h04);
    rd(3'd2, 8'hC6, "R3 parity line status");
    parity_err = 0; step();
    rd(3'd2, 8'hC1, "R3 no error bits");
    // R8 LSR read clears overrun and break
    overrun_ev = 1; step();
    break_ev = 1; step();
    rd(3'd2, 8'hC6, "R3 overrun/break line status");
    rd(3'd5, 8'h73, "R8 LSR pre-clear value");
    rd(3'd5, 8'h61, "R8 LSR after clear");
    rd(3'd2, 8'hC1, "R8 line interrupt gone");
    // R1 all sources stacked
    wr(3'd1, 8'h0F);
    thr_drained = 1; rx_timeout = 1; parity_err = 1; msr_delta = 4'h1; step();
    rd(3'd2, 8'hC6, "R1 line first");
    parity_err = 0; step();
    rd(3'd2, 8'hCC, "R1 timeout second");
    rx_timeout = 0; step();
    rd(3'd2, 8'hC4, "R1 data third");
    rx_ready = 0; step();
    rd(3'd2, 8'hC2, "R1 THR fourth");
    rd(3'd2, 8'hC0, "R1 modem last");
    msr_delta = 0; step(); step();
    check(irq == 0, "R9 irq drops", irq, 0);
    rd(3'd2, 8'hC1, "R2 nothing pending");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule